// File: doc/BRIEF.md
# Issue-Stage Operand Interlock Scoreboard

This block sits in front of the execute pipes of a small in-order core. Each cycle it looks at one decoded instruction and decides whether that instruction may issue in this cycle or must wait. An instruction arrives with an operation class, up to two source registers and an optional destination register. Each source carries a flag that says whether it is consumed early or late. Early use covers a shift amount or shift value, a multiplier input and a store address. All other uses are late.

For every architectural register the block keeps two countdowns: one for early consumers and one for late consumers. A single producer can therefore become ready at two different times, depending on how the consumer reads the value. Next to this table, the block keeps a short reservation window for each of four shared stages: the first execute stage, the execute writeback, the load/store address stage and the first data-cache stage. An instruction that needs a stage slot already claimed by an older instruction is held. A held instruction stays on the inputs, unchanged, until it issues.

Top module: `isb_interlock`

## Requirements
- R1: After reset, every register countdown and every stage reservation is empty. The first valid instruction issues in the cycle it is presented. A reset in mid-run discards all pending results and reservations.
- R2: `issue` and `stall` are never both high. Both are low while `in_valid` is low. While `in_valid` is high, exactly one of them is high. A stalled instruction is held with stable inputs until it issues.
- R3: Class code 0 (ALU, plain or constant shift) is usable by a late consumer in the cycle after issue, and by an early consumer two cycles after issue.
- R4: Class code 1 (ALU with register-specified shift) holds the first execute stage for 2 cycles. Its result is ready 2 cycles after issue for late use and 3 cycles after issue for early use.
- R5: Class code 2 (32-bit multiply or multiply-accumulate) holds the first execute stage for 2 cycles. Its latency is 3 for late use and 4 for early use.
- R6: Class code 3 (32x32 to 64 long multiply) holds the first execute stage for 3 cycles and the execute writeback for 2 cycles, at issue offsets 5 and 6. Its latency is 4 for late use and 5 for early use.
- R7: Class code 4 (16x16 multiply) holds the first execute stage for a single cycle. Its latency is 2 for late use and 3 for early use.
- R8: Class code 5 (word or doubleword load) has latency 2 for late use and 3 for early use. Class code 6 (byte load) has latency 3 for late use and 4 for early use.
- R9: Class code 7 (load multiple) has latency 3 for late use and 4 for early use. It holds the first data-cache stage at issue offsets 1 and 2.
- R10: Loads and stores (codes 5 to 9) claim the load/store address stage and the first execute stage in their issue cycle, and do not use the execute writeback. Stores (code 8 single, code 9 multiple, the latter holding the first data-cache stage for 2 cycles) write no register even if `dst_en` is set.
- R11: A source with its enable low never causes a stall. For an enabled source, the early or late countdown is chosen by that source's early flag.
- R12: When an issuing instruction writes a register that still has a pending result, each countdown of that register takes the later of the remaining and the new readiness.
- R13: Class codes 10 to 15 issue whenever valid, reserve no stage and write no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A decoded instruction is presented |
| in_class | input | 4 | Operation class code (see requirements) |
| src0_en | input | 1 | Source 0 is read |
| src0_reg | input | 4 | Source 0 register number |
| src0_early | input | 1 | Source 0 is consumed early |
| src1_en | input | 1 | Source 1 is read |
| src1_reg | input | 4 | Source 1 register number |
| src1_early | input | 1 | Source 1 is consumed early |
| dst_en | input | 1 | Instruction writes a destination register |
| dst_reg | input | 4 | Destination register number |
| issue | output | 1 | Instruction issues this cycle |
| stall | output | 1 | Instruction is held this cycle |

## Verification
Several properties are checked by assertions on every cycle: `issue` and `stall` stay mutually exclusive and follow `in_valid`, each countdown falls by one per cycle unless it is rewritten, the late countdown never exceeds the early countdown, the countdowns stay within the largest latency, and no instruction issues over a pending source or a claimed stage slot. The exact number of stall cycles cannot be seen by those properties, because it comes from the interaction of producer class, consumer use, register overlap and stage collisions. Only the bench's producer and consumer pairs show those counts, including the writeback clash behind a long multiply, the doubled data-cache slot of a load multiple, the overlapping write of one register, and reset in mid-run.

// File: rtl/isb_pkg.sv
package isb_pkg;

  localparam int RES_DEPTH = 8;
  localparam int NUM_RES   = 4;
  localparam int RES_EX1   = 0;
  localparam int RES_EXWB  = 1;
  localparam int RES_LSA   = 2;
  localparam int RES_DC1   = 3;
  localparam int MAX_LAT   = 5;

  typedef enum logic [3:0] {
    CLS_ALU       = 4'd0,
    CLS_ALU_SHREG = 4'd1,
    CLS_MUL32     = 4'd2,
    CLS_MUL64     = 4'd3,
    CLS_MUL16     = 4'd4,
    CLS_LD_WORD   = 4'd5,
    CLS_LD_BYTE   = 4'd6,
    CLS_LD_MULTI  = 4'd7,
    CLS_ST        = 4'd8,
    CLS_ST_MULTI  = 4'd9
  } op_class_e;

  // Cycles from issue until an early consumer may issue.
  function automatic int unsigned lat_early(input logic [3:0] cls);
    case (cls)
      CLS_ALU:       return 2;
      CLS_ALU_SHREG: return 3;
      CLS_MUL32:     return 4;
      CLS_MUL64:     return 5;
      CLS_MUL16:     return 3;
      CLS_LD_WORD:   return 3;
      CLS_LD_BYTE:   return 4;
      CLS_LD_MULTI:  return 4;
      default:       return 0;
    endcase
  endfunction

  // Cycles from issue until a late consumer may issue.
  function automatic int unsigned lat_late(input logic [3:0] cls);
    case (cls)
      CLS_ALU:       return 1;
      CLS_ALU_SHREG: return 2;
      CLS_MUL32:     return 3;
      CLS_MUL64:     return 4;
      CLS_MUL16:     return 2;
      CLS_LD_WORD:   return 2;
      CLS_LD_BYTE:   return 3;
      CLS_LD_MULTI:  return 3;
      default:       return 0;
    endcase
  endfunction

  function automatic logic writes_reg(input logic [3:0] cls);
    return cls <= CLS_LD_MULTI;
  endfunction

  function automatic logic is_mem(input logic [3:0] cls);
    return (cls >= CLS_LD_WORD) && (cls <= CLS_ST_MULTI);
  endfunction

  // Cycles the first execute stage is held.
  function automatic int unsigned ex1_hold(input logic [3:0] cls);
    case (cls)
      CLS_ALU_SHREG, CLS_MUL32: return 2;
      CLS_MUL64:                return 3;
      CLS_ALU, CLS_MUL16:       return 1;
      default:                  return is_mem(cls) ? 1 : 0;
    endcase
  endfunction

  // Slot mask of one stage for one class; bit k is the cycle issue+k.
  function automatic logic [RES_DEPTH-1:0] res_need(input logic [3:0] cls,
                                                    input int res);
    logic [RES_DEPTH-1:0] m;
    int unsigned h;
    m = '0;
    h = ex1_hold(cls);
    case (res)
      RES_EX1: begin
        for (int k = 0; k < 3; k++)
          if (k < int'(h)) m[k] = 1'b1;
      end
      RES_EXWB: begin
        if (cls <= CLS_MUL16) m[h + 2] = 1'b1;
        if (cls == CLS_MUL64) m[h + 3] = 1'b1;
      end
      RES_LSA: m[0] = is_mem(cls);
      RES_DC1: begin
        m[1] = is_mem(cls);
        m[2] = (cls == CLS_LD_MULTI) || (cls == CLS_ST_MULTI);
      end
      default: m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/isb_ready_table.sv
module isb_ready_table #(
  parameter int NUM_REGS = 16,
  parameter int CNT_W    = 3,
  parameter int MAX_CNT  = 4,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [REG_W-1:0]    wr_reg,
  input  logic [CNT_W-1:0]    wr_early,
  input  logic [CNT_W-1:0]    wr_late,
  output logic [NUM_REGS-1:0] pend_early,
  output logic [NUM_REGS-1:0] pend_late
);

  function automatic logic [CNT_W-1:0] later(input logic [CNT_W-1:0] a,
                                             input logic [CNT_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [CNT_W-1:0] decay(input logic [CNT_W-1:0] c);
    return (c != '0) ? c - 1'b1 : '0;
  endfunction

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [CNT_W-1:0] cnt_e, cnt_l;
    logic [CNT_W-1:0] nxt_e, nxt_l;
    logic             hit;

    assign hit = wr_en && (wr_reg == REG_W'(g));

    always_comb begin
      nxt_e = decay(cnt_e);
      nxt_l = decay(cnt_l);
      if (hit) begin
        nxt_e = later(nxt_e, wr_early);
        nxt_l = later(nxt_l, wr_late);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_e <= '0;
        cnt_l <= '0;
      end else begin
        cnt_e <= nxt_e;
        cnt_l <= nxt_l;
      end
    end

    assign pend_early[g] = (cnt_e != '0);
    assign pend_late[g]  = (cnt_l != '0);

    // R1
    count_decay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit && cnt_e != '0) |=> (cnt_e == $past(cnt_e) - 1'b1));
    // R11
    late_before_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_l <= cnt_e);
    // R6
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_e <= CNT_W'(MAX_CNT));
  end

endmodule

// File: rtl/isb_resource_track.sv
module isb_resource_track #(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] need,
  input  logic             claim,
  output logic             conflict
);

  logic [DEPTH-1:0] occ;

  assign conflict = |(occ & need);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ <= '0;
    else        occ <= (occ >> 1) | (claim ? (need >> 1) : '0);
  end

  // R10
  slot_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (claim && need[1]) |=> occ[0]);
  // R1
  slot_double_chk: assert property (@(posedge clk) disable iff (!rst_n)
    claim |-> !conflict);

endmodule

// File: rtl/isb_interlock.sv
module isb_interlock
  import isb_pkg::*;
#(
  parameter int NUM_REGS = 16,
  parameter int CNT_W    = 3,
  parameter int DEPTH    = isb_pkg::RES_DEPTH,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [3:0]       in_class,
  input  logic             src0_en,
  input  logic [REG_W-1:0] src0_reg,
  input  logic             src0_early,
  input  logic             src1_en,
  input  logic [REG_W-1:0] src1_reg,
  input  logic             src1_early,
  input  logic             dst_en,
  input  logic [REG_W-1:0] dst_reg,
  output logic             issue,
  output logic             stall
);

  logic [NUM_REGS-1:0] pend_early, pend_late;
  logic                src0_wait, src1_wait, data_hazard;
  logic [NUM_RES-1:0]  res_conflict;
  logic                struct_hazard;
  logic                wr_en;
  logic [CNT_W-1:0]    wr_early, wr_late;
  int unsigned         le, ll;

  // Operand readiness per source, selected by its use stage.
  assign src0_wait = src0_en &&
                     (src0_early ? pend_early[src0_reg] : pend_late[src0_reg]);
  assign src1_wait = src1_en &&
                     (src1_early ? pend_early[src1_reg] : pend_late[src1_reg]);
  assign data_hazard = src0_wait || src1_wait;

  for (genvar r = 0; r < NUM_RES; r++) begin : g_res
    logic [DEPTH-1:0] need;
    assign need = res_need(in_class, r);
    isb_resource_track #(.DEPTH(DEPTH)) u_trk (
      .clk      (clk),
      .rst_n    (rst_n),
      .need     (need),
      .claim    (issue),
      .conflict (res_conflict[r])
    );
  end

  assign struct_hazard = |res_conflict;
  assign issue = in_valid && !data_hazard && !struct_hazard;
  assign stall = in_valid && (data_hazard || struct_hazard);

  // Countdown values are latency minus one: a count of zero means ready.
  always_comb begin
    le = lat_early(in_class);
    ll = lat_late(in_class);
    wr_early = (le > 0) ? CNT_W'(le - 1) : '0;
    wr_late  = (ll > 0) ? CNT_W'(ll - 1) : '0;
  end

  assign wr_en = issue && dst_en && writes_reg(in_class);

  isb_ready_table #(.NUM_REGS(NUM_REGS), .CNT_W(CNT_W), .MAX_CNT(MAX_LAT - 1)) u_tbl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_reg     (dst_reg),
    .wr_early   (wr_early),
    .wr_late    (wr_late),
    .pend_early (pend_early),
    .pend_late  (pend_late)
  );

  // R2
  issue_stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue && stall));
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> (!issue && !stall));
  // R2
  held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (in_valid && $stable(in_class) && $stable(dst_reg)));
  // R11
  no_pending_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> !(src0_en && (src0_early ? pend_early[src0_reg] : pend_late[src0_reg])));
  // R10
  stage_free_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (res_conflict == '0));

endmodule

// File: tb/isb_interlock_test.sv
module isb_interlock_test;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [3:0] pc;    // producer class
    logic [3:0] cc;    // consumer class
    logic [1:0] sel;   // 0 indep, 1 src0 dep, 2 src1 dep, 3 src0 match but disabled
    logic       early; // dependent source consumed early
    logic [3:0] exp;   // expected stall cycles of the consumer
    logic [3:0] req;   // requirement number
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{4'd0, 4'd0, 2'd1, 1'b0, 4'd0, 4'd3},   // R3 late
    '{4'd0, 4'd0, 2'd1, 1'b1, 4'd1, 4'd3},   // R3 early
    '{4'd1, 4'd0, 2'd1, 1'b0, 4'd1, 4'd4},   // R4 late
    '{4'd1, 4'd0, 2'd2, 1'b1, 4'd2, 4'd4},   // R4 early via src1
    '{4'd2, 4'd0, 2'd1, 1'b0, 4'd2, 4'd5},   // R5 late
    '{4'd2, 4'd2, 2'd1, 1'b1, 4'd3, 4'd5},   // R5 early
    '{4'd3, 4'd0, 2'd1, 1'b0, 4'd3, 4'd6},   // R6 late
    '{4'd3, 4'd0, 2'd1, 1'b1, 4'd4, 4'd6},   // R6 early
    '{4'd4, 4'd0, 2'd1, 1'b0, 4'd1, 4'd7},   // R7 late
    '{4'd4, 4'd0, 2'd2, 1'b1, 4'd2, 4'd7},   // R7 early
    '{4'd5, 4'd0, 2'd1, 1'b0, 4'd1, 4'd8},   // R8 word late
    '{4'd5, 4'd8, 2'd1, 1'b1, 4'd2, 4'd8},   // R8 word to store address
    '{4'd6, 4'd0, 2'd1, 1'b0, 4'd2, 4'd8},   // R8 byte late
    '{4'd6, 4'd0, 2'd1, 1'b1, 4'd3, 4'd8},   // R8 byte early
    '{4'd7, 4'd0, 2'd1, 1'b0, 4'd2, 4'd9},   // R9 late
    '{4'd7, 4'd0, 2'd1, 1'b1, 4'd3, 4'd9},   // R9 early
    '{4'd7, 4'd5, 2'd0, 1'b0, 4'd1, 4'd9},   // R9 data-cache slot
    '{4'd5, 4'd5, 2'd0, 1'b0, 4'd0, 4'd10},  // R10 back-to-back loads
    '{4'd9, 4'd8, 2'd0, 1'b0, 4'd1, 4'd10},  // R10 store multiple slot
    '{4'd3, 4'd0, 2'd0, 1'b0, 4'd3, 4'd6},   // R6 writeback clash
    '{4'd3, 4'd1, 2'd0, 1'b0, 4'd2, 4'd6},   // R6 execute hold only
    '{4'd2, 4'd0, 2'd0, 1'b0, 4'd1, 4'd5},   // R5 execute hold
    '{4'd0, 4'd8, 2'd2, 1'b0, 4'd0, 4'd10},  // R10 store data late
    '{4'd0, 4'd0, 2'd3, 1'b1, 4'd0, 4'd11},  // R11 disabled source
    '{4'd8, 4'd0, 2'd1, 1'b1, 4'd0, 4'd10},  // R10 store writes nothing
    '{4'd12, 4'd0, 2'd1, 1'b1, 4'd0, 4'd13}, // R13 reserved class
    '{4'd1, 4'd1, 2'd0, 1'b0, 4'd1, 4'd4},   // R4 execute hold
    '{4'd4, 4'd0, 2'd0, 1'b0, 4'd0, 4'd7}    // R7 single execute cycle
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [3:0] in_class = '0;
  logic       src0_en = 1'b0, src0_early = 1'b0;
  logic [3:0] src0_reg = '0;
  logic       src1_en = 1'b0, src1_early = 1'b0;
  logic [3:0] src1_reg = '0;
  logic       dst_en = 1'b0;
  logic [3:0] dst_reg = '0;
  logic       issue, stall;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  isb_interlock uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
    .src0_en(src0_en), .src0_reg(src0_reg), .src0_early(src0_early),
    .src1_en(src1_en), .src1_reg(src1_reg), .src1_early(src1_early),
    .dst_en(dst_en), .dst_reg(dst_reg), .issue(issue), .stall(stall)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called just after a falling edge; presents one instruction, returns
  // the number of stalled cycles, and leaves just after the next falling edge.
  task automatic send(input logic [3:0] cls,
                      input logic e0, input logic [3:0] r0, input logic x0,
                      input logic e1, input logic [3:0] r1, input logic x1,
                      input logic de, input logic [3:0] d,
                      output int stalls);
    in_valid = 1'b1; in_class = cls;
    src0_en = e0; src0_reg = r0; src0_early = x0;
    src1_en = e1; src1_reg = r1; src1_early = x1;
    dst_en = de; dst_reg = d;
    stalls = 0;
    #1;
    while (!issue && stalls < 40) begin
      @(negedge clk);
      stalls++;
      #1;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int st;
    logic s0, s1, dx;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: idle inputs give neither issue nor stall
    #1;
    check("R2 idle issue", int'(issue), 0);
    check("R2 idle stall", int'(stall), 0);
    @(negedge clk);

    // R1: first instruction after reset issues at once
    send(4'd2, 1'b1, 4'd1, 1'b1, 1'b1, 4'd2, 1'b1, 1'b1, 4'd4, st);
    check("R1 first issue", st, 0);
    idle(10);

    // Table of producer and consumer pairs
    for (int v = 0; v < NV; v++) begin
      send(VECS[v].pc, 1'b1, 4'd1, 1'b0, 1'b1, 4'd2, 1'b0, 1'b1, 4'd3, st);
      s0 = (VECS[v].sel == 2'd1) || (VECS[v].sel == 2'd3);
      s1 = (VECS[v].sel == 2'd2);
      dx = (VECS[v].cc <= 4'd7);
      send(VECS[v].cc,
           !(VECS[v].sel == 2'd3), s0 ? 4'd3 : 4'd8, s0 ? VECS[v].early : 1'b1,
           1'b1, s1 ? 4'd3 : 4'd9, s1 ? VECS[v].early : 1'b1,
           dx, 4'd10, st);
      check($sformatf("R%0d vector %0d", VECS[v].req, v), st, int'(VECS[v].exp));
      idle(10);
    end

    // R2: while held, stall is high and issue low
    send(4'd3, 1'b0, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b1, 4'd5, st);
    in_valid = 1'b1; in_class = 4'd0;
    src0_en = 1'b1; src0_reg = 4'd5; src0_early = 1'b1;
    src1_en = 1'b0; dst_en = 1'b0;
    #1;
    check("R2 held stall", int'(stall), 1);
    check("R2 held issue", int'(issue), 0);
    idle(10);

    // R12: overlapping write keeps the later readiness
    send(4'd6, 1'b0, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b1, 4'd5, st);
    send(4'd0, 1'b1, 4'd8, 1'b0, 1'b0, 4'd0, 1'b0, 1'b1, 4'd5, st);
    check("R12 second writer", st, 0);
    send(4'd0, 1'b1, 4'd5, 1'b1, 1'b0, 4'd0, 1'b0, 1'b0, 4'd0, st);
    check("R12 consumer", st, 2);
    idle(10);

    // R1: reset in mid-run clears countdowns and reservations
    send(4'd3, 1'b0, 4'd0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b1, 4'd6, st);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    send(4'd0, 1'b1, 4'd6, 1'b1, 1'b0, 4'd0, 1'b0, 1'b0, 4'd0, st);
    check("R1 after mid-run reset", st, 0);
    idle(4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule